// File: doc/BRIEF.md
# Stereo Tone Processor Control Slave

This block is the write-only serial control port of a stereo tone and volume processor. It watches the two wires of an I2C bus, sampled by a fast system clock, and finds start and stop conditions. It compares the first byte of a transfer against a 7-bit module address set by a parameter, and acknowledges only a write to that address. The byte after the address is a subaddress. Every byte after that writes one control register and moves the subaddress on to the next register.

There are five registers: left volume, right volume, bass, treble, and a switch byte. The switch byte holds mute, stereo/spatial/mono selection and input source selection. The register outputs drive the analog gain stages directly. A sticky flag reports that the forbidden stereo-mode combination was written. After reset the outputs start muted and stay muted until software writes the switch byte.

Top module: `tone_ctrl_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start and a rising SDA while SCL is high is a stop. A start, even in the middle of a byte or a transfer, puts the receiver back at the address byte, and a partly received byte writes nothing.
- R2: An address byte equal to {DEV_ADDR, 0} is acknowledged by pulling SDA low (sdaPullLow = 1) through the ninth SCL pulse. Any other address, including the read bit set, gets no acknowledge, and the bytes after it are neither acknowledged nor written until the next start.
- R3: The byte after a matched address is the subaddress and is always acknowledged. The subaddresses 0x00, 0x01, 0x02, 0x03 and 0x08 select left volume, right volume, bass, treble and the switch byte.
- R4: A volume write stores data bits 5..0 in volLeft or volRight. A bass or treble write stores data bits 3..0 in bassCode or trebleCode. Every accepted data byte is acknowledged.
- R5: A switch byte write sets muteOn from bit 5, stereoSel from {bit 3, bit 4} (11 spatial, 10 stereo, 00 mono) and inputSel from {bit 2, bit 1}.
- R6: After each data write the subaddress advances 0x00 to 0x01 to 0x02 to 0x03 to 0x08. At 0x08 it stays, so further bytes rewrite the switch byte.
- R7: A data byte sent to any other subaddress is acknowledged but changes no output, and the subaddress does not advance.
- R8: After reset: volLeft = volRight = 0, bassCode = trebleCode = 0x6, inputSel = 11, stereoSel = 10, muteOn = 1, modeErr = 0. Mute is released only by a switch byte write with bit 5 = 0.
- R9: A switch byte write with stereoSel = 01 is stored as written and sets modeErr. modeErr stays set until reset.
- R10: Register outputs and sdaPullLow change exactly 3 clock cycles after the SCL falling edge that ends the eighth bit. sdaPullLow goes low again 3 cycles after the SCL falling edge that ends the ninth pulse.
- R11: After a stop, SCL pulses with no new start are ignored: no acknowledge and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaPullLow | output | 1 | 1 pulls the data line low (acknowledge) |
| volLeft | output | 6 | Left volume code |
| volRight | output | 6 | Right volume code |
| bassCode | output | 4 | Bass step code |
| trebleCode | output | 4 | Treble step code |
| inputSel | output | 2 | Source select: 11 stereo, 01 first sound, 10 second sound |
| stereoSel | output | 2 | 11 spatial, 10 stereo, 00 mono, 01 forbidden |
| muteOn | output | 1 | Output mute, 1 after reset |
| modeErr | output | 1 | Sticky flag for a forbidden stereo-mode write |

## Verification
Each bus change passes through two synchronizer flops and then the edge register. So register writes and the acknowledge are due on the third rising clock edge after the bench moves SCL low at the end of the eighth bit. The acknowledge release is due three edges after the ninth falling edge. The bench puts every predicted effect in a queue with its due cycle, stamped when the bench drives the edge. Just after each rising edge it applies every entry that has come due and compares all outputs against the model. An output that moves one cycle early or late therefore shows up as a mismatch. Literal end-of-test checks and an acknowledge sample in the middle of each ninth SCL high phase back this up.

// File: rtl/tone_slave_pkg.sv
package tone_slave_pkg;
  localparam int ByteW = 8;
  localparam int VolW = 6;
  localparam int ToneW = 4;
  localparam int CntW = $clog2(ByteW + 1);

  // subaddress map (order matters for auto-increment)
  localparam logic [ByteW-1:0] SubVolL   = 8'h00;
  localparam logic [ByteW-1:0] SubVolR   = 8'h01;
  localparam logic [ByteW-1:0] SubBass   = 8'h02;
  localparam logic [ByteW-1:0] SubTreble = 8'h03;
  localparam logic [ByteW-1:0] SubSwitch = 8'h08;

  // switch byte field positions
  localparam int MuteBit   = 5;
  localparam int SpreadBit = 4;
  localparam int StereoBit = 3;
  localparam int SelHiBit  = 2;
  localparam int SelLoBit  = 1;

  localparam logic [VolW-1:0]  VolReset  = '0;
  localparam logic [ToneW-1:0] ToneFlat  = 4'h6;
  localparam logic [1:0]       SelReset  = 2'b11;
  localparam logic [1:0]       ModeReset = 2'b10;
  localparam logic [1:0]       ModeBad   = 2'b01;

  typedef enum logic [2:0] {
    BusIdle, BusAddr, BusSub, BusData, BusSkip
  } busState_t;

  typedef struct packed {
    logic             loadSub;
    logic             writeData;
    logic [ByteW-1:0] dataByte;
  } regStrobe_t;
endpackage

// File: rtl/bus_edge_detect.sv
module bus_edge_detect #(
  parameter int SYNC_STAGES = 2  // must be 2 or more
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaNow,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  localparam int Top = SYNC_STAGES - 1;

  logic [Top:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[Top-1:0], sclIn};
      sdaSync <= {sdaSync[Top-1:0], sdaIn};
      sclPrev <= sclSync[Top];
      sdaPrev <= sdaSync[Top];
    end
  end

  assign sclNow    = sclSync[Top];
  assign sdaNow    = sdaSync[Top];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import tone_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaNow,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  output regStrobe_t stb,
  output logic       ackDrive
);
  busState_t        state, nextState;
  logic [CntW-1:0]  bitCnt;
  logic [ByteW-1:0] shiftReg;
  logic             ackPhase;
  logic             byteDone, accept;

  assign byteDone = sclFall && !ackPhase && (bitCnt == CntW'(ByteW)) && (state != BusIdle);

  always_comb begin
    accept    = 1'b0;
    nextState = state;
    case (state)
      BusAddr: begin
        accept    = (shiftReg == {DEV_ADDR, 1'b0});
        nextState = accept ? BusSub : BusSkip;
      end
      BusSub: begin
        accept    = 1'b1;
        nextState = BusData;
      end
      BusData: accept = 1'b1;
      default: accept = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= BusIdle;
      bitCnt   <= '0;
      shiftReg <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
    end else if (startSeen) begin
      state    <= BusAddr;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopSeen) begin
      state    <= BusIdle;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
    end else if (state != BusIdle) begin
      if (sclRise && !ackPhase && bitCnt < CntW'(ByteW)) begin
        shiftReg <= {shiftReg[ByteW-2:0], sdaNow};
        bitCnt   <= bitCnt + 1'b1;
      end else if (sclFall && ackPhase) begin
        ackPhase <= 1'b0;
        ackDrive <= 1'b0;
        bitCnt   <= '0;
      end else if (byteDone) begin
        ackPhase <= 1'b1;
        ackDrive <= accept;
        state    <= nextState;
      end
    end
  end

  assign stb.loadSub   = byteDone && (state == BusSub);
  assign stb.writeData = byteDone && (state == BusData);
  assign stb.dataByte  = shiftReg;

  // R2
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == BusIdle) |-> !ackDrive);

  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackDrive && !sclFall && !startSeen && !stopSeen) |=> ackDrive);

  // R2
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CntW'(ByteW));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == BusIdle && !startSeen) |=> !stb.writeData && !stb.loadSub);
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import tone_slave_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       stb,
  output logic [VolW-1:0]  volLeft,
  output logic [VolW-1:0]  volRight,
  output logic [ToneW-1:0] bassCode,
  output logic [ToneW-1:0] trebleCode,
  output logic [1:0]       inputSel,
  output logic [1:0]       stereoSel,
  output logic             muteOn,
  output logic             modeErr
);
  logic [ByteW-1:0] subAddr;
  logic [1:0]       newMode;
  logic             listed;

  assign newMode = {stb.dataByte[StereoBit], stb.dataByte[SpreadBit]};
  assign listed  = (subAddr == SubVolL) || (subAddr == SubVolR) || (subAddr == SubBass) ||
                   (subAddr == SubTreble) || (subAddr == SubSwitch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subAddr    <= SubVolL;
      volLeft    <= VolReset;
      volRight   <= VolReset;
      bassCode   <= ToneFlat;
      trebleCode <= ToneFlat;
      inputSel   <= SelReset;
      stereoSel  <= ModeReset;
      muteOn     <= 1'b1;
      modeErr    <= 1'b0;
    end else if (stb.loadSub) begin
      subAddr <= stb.dataByte;
    end else if (stb.writeData) begin
      case (subAddr)
        SubVolL: begin
          volLeft <= stb.dataByte[VolW-1:0];
          subAddr <= SubVolR;
        end
        SubVolR: begin
          volRight <= stb.dataByte[VolW-1:0];
          subAddr  <= SubBass;
        end
        SubBass: begin
          bassCode <= stb.dataByte[ToneW-1:0];
          subAddr  <= SubTreble;
        end
        SubTreble: begin
          trebleCode <= stb.dataByte[ToneW-1:0];
          subAddr    <= SubSwitch;
        end
        SubSwitch: begin
          muteOn    <= stb.dataByte[MuteBit];
          stereoSel <= newMode;
          inputSel  <= {stb.dataByte[SelHiBit], stb.dataByte[SelLoBit]};
          if (newMode == ModeBad) modeErr <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8
  mute_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(muteOn) |-> $past(stb.writeData && subAddr == SubSwitch));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |=> modeErr);

  // R6
  inc_to_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeData && subAddr == SubTreble) |=> (subAddr == SubSwitch));

  // R7
  unlisted_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeData && !listed) |=> ($stable(subAddr) && $stable(volLeft) && $stable(volRight) &&
      $stable(bassCode) && $stable(trebleCode) && $stable(muteOn) && $stable(stereoSel)));
endmodule

// File: rtl/tone_ctrl_slave.sv
module tone_ctrl_slave
  import tone_slave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h41,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  output logic [VolW-1:0]  volLeft,
  output logic [VolW-1:0]  volRight,
  output logic [ToneW-1:0] bassCode,
  output logic [ToneW-1:0] trebleCode,
  output logic [1:0]       inputSel,
  output logic [1:0]       stereoSel,
  output logic             muteOn,
  output logic             modeErr
);
  logic sdaNow, sclRise, sclFall, startSeen, stopSeen;
  regStrobe_t stb;

  bus_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) uEdge (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  i2c_slave_ctrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rstN(rstN), .sdaNow(sdaNow), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .stb(stb), .ackDrive(sdaPullLow)
  );

  ctrl_reg_bank uRegs (
    .clk(clk), .rstN(rstN), .stb(stb),
    .volLeft(volLeft), .volRight(volRight), .bassCode(bassCode), .trebleCode(trebleCode),
    .inputSel(inputSel), .stereoSel(stereoSel), .muteOn(muteOn), .modeErr(modeErr)
  );
endmodule

// File: tb/tb_tone_ctrl_slave.sv
`timescale 1ns/1ps
module tb_tone_ctrl_slave;
  localparam int H = 10;            // half SCL period in clocks
  localparam logic [7:0] AddrW = 8'h82;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaBus;
  logic sdaPullLow, muteOn, modeErr;
  logic [5:0] volLeft, volRight;
  logic [3:0] bassCode, trebleCode;
  logic [1:0] inputSel, stereoSel;

  always #5 clk = ~clk;
  assign sdaBus = sdaDrv & ~sdaPullLow;

  tone_ctrl_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .sdaPullLow(sdaPullLow),
    .volLeft(volLeft), .volRight(volRight), .bassCode(bassCode), .trebleCode(trebleCode),
    .inputSel(inputSel), .stereoSel(stereoSel), .muteOn(muteOn), .modeErr(modeErr)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int mVolL = 0, mVolR = 0, mBass = 6, mTreb = 6, mSel = 3, mMode = 2;
  int mMute = 1, mErr = 0, mAck = 0, mSub = 0, mPhase = 0;
  int dueQ[$], kindQ[$], byteQ[$];

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic modelWrite(input int b);
    int st;
    case (mSub)
      0: begin mVolL = b & 63; mSub = 1; end
      1: begin mVolR = b & 63; mSub = 2; end
      2: begin mBass = b & 15; mSub = 3; end
      3: begin mTreb = b & 15; mSub = 8; end
      8: begin
        mMute = (b >> 5) & 1;
        st = ((b >> 3) & 1) * 2 + ((b >> 4) & 1);
        mMode = st;
        if (st == 1) mErr = 1;
        mSel = (b >> 1) & 3;
      end
      default: ;
    endcase
  endtask

  task automatic modelApply(input int kind, input int b);
    if (kind == 0) mAck = 0;
    else begin
      case (mPhase)
        1: if (b == AddrW) begin mAck = 1; mPhase = 2; end else begin mAck = 0; mPhase = 4; end
        2: begin mAck = 1; mSub = b; mPhase = 3; end
        3: begin mAck = 1; modelWrite(b); end
        default: mAck = 0;
      endcase
    end
  endtask

  // per-clock comparison, just after each rising edge
  always @(posedge clk) begin
    cyc++;
    #1;
    while (dueQ.size() > 0 && dueQ[0] <= cyc) begin
      modelApply(kindQ[0], byteQ[0]);
      void'(dueQ.pop_front()); void'(kindQ.pop_front()); void'(byteQ.pop_front());
    end
    if (!finished) begin
      check("R10/R2 sdaPullLow", sdaPullLow, mAck);
      check("R10/R4 volLeft", volLeft, mVolL);
      check("R10/R4 volRight", volRight, mVolR);
      check("R10/R4 bassCode", bassCode, mBass);
      check("R10/R4 trebleCode", trebleCode, mTreb);
      check("R10/R5 inputSel", inputSel, mSel);
      check("R10/R5 stereoSel", stereoSel, mMode);
      check("R10/R8 muteOn", muteOn, mMute);
      check("R10/R9 modeErr", modeErr, mErr);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic schedule(input int kind, input int b);
    dueQ.push_back(cyc + 3); kindQ.push_back(kind); byteQ.push_back(b);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitClk(H / 2);
    sclDrv = 1'b1; waitClk(H);
    sdaDrv = 1'b0; mPhase = 1; waitClk(H);
    sclDrv = 1'b0; waitClk(H / 2);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitClk(H / 2);
    sclDrv = 1'b1; waitClk(H);
    sdaDrv = 1'b1; mPhase = 0; waitClk(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; waitClk(H / 2);
      sclDrv = 1'b1; waitClk(H);
      sclDrv = 1'b0;
      if (i == 0) schedule(1, int'(b));
      waitClk(H / 2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input string req);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitClk(H / 2);
    sclDrv = 1'b1; waitClk(H / 2);
    check({req, " ack on ninth clock"}, (sdaBus == 1'b0) ? 1 : 0, expAck ? 1 : 0);
    waitClk(H / 2);
    sclDrv = 1'b0; schedule(0, 0);
    waitClk(H / 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R8 reset state
    check("R8 reset volLeft", volLeft, 0);
    check("R8 reset volRight", volRight, 0);
    check("R8 reset bass", bassCode, 6);
    check("R8 reset treble", trebleCode, 6);
    check("R8 reset inputSel", inputSel, 3);
    check("R8 reset stereoSel", stereoSel, 2);
    check("R8 reset mute", muteOn, 1);
    check("R8 reset modeErr", modeErr, 0);

    // R3 R4 R5 R6: full load with auto-increment
    busStart();
    sendByte(AddrW, 1, "R2");
    sendByte(8'h00, 1, "R3");
    sendByte(8'hFF, 1, "R4");
    sendByte(8'hDB, 1, "R4");
    sendByte(8'hFB, 1, "R4");
    sendByte(8'hF2, 1, "R4");
    sendByte(8'hDF, 1, "R5");
    check("R5 mute cleared", muteOn, 0);
    check("R5 spatial", stereoSel, 3);
    sendByte(8'hCB, 1, "R6");
    busStop();
    check("R4 volLeft", volLeft, 6'h3F);
    check("R4 volRight", volRight, 6'h1B);
    check("R4 bass", bassCode, 4'hB);
    check("R3 treble", trebleCode, 4'h2);
    check("R6 switch rewritten stereoSel", stereoSel, 2);
    check("R6 switch rewritten inputSel", inputSel, 1);

    // R7: unlisted subaddress
    busStart();
    sendByte(AddrW, 1, "R2");
    sendByte(8'h05, 1, "R7");
    sendByte(8'hC5, 1, "R7");
    sendByte(8'hC7, 1, "R7");
    busStop();
    check("R7 volLeft kept", volLeft, 6'h3F);
    check("R7 volRight kept", volRight, 6'h1B);

    // R2: wrong address and read bit
    busStart();
    sendByte(8'h84, 0, "R2");
    sendByte(8'h00, 0, "R2");
    sendByte(8'hC1, 0, "R2");
    busStop();
    busStart();
    sendByte(8'h83, 0, "R2");
    sendByte(8'h00, 0, "R2");
    sendByte(8'hC2, 0, "R2");
    busStop();
    check("R2 volLeft kept", volLeft, 6'h3F);

    // R9: forbidden mode code, then valid one
    busStart();
    sendByte(AddrW, 1, "R2");
    sendByte(8'h08, 1, "R3");
    sendByte(8'hF7, 1, "R9");
    busStop();
    check("R9 flag set", modeErr, 1);
    check("R9 code stored", stereoSel, 1);
    check("R9 mute set again", muteOn, 1);
    busStart();
    sendByte(AddrW, 1, "R2");
    sendByte(8'h08, 1, "R3");
    sendByte(8'hDF, 1, "R9");
    busStop();
    check("R9 flag sticky", modeErr, 1);
    check("R9 new code", stereoSel, 3);

    // R1: repeated start after a full byte and in the middle of a byte
    busStart();
    sendByte(AddrW, 1, "R1");
    sendByte(8'h02, 1, "R1");
    sendByte(8'hF9, 1, "R1");
    busStart();
    sendByte(AddrW, 1, "R1");
    sendByte(8'h00, 1, "R1");
    sendBits(8'hC4, 4);
    busStart();
    sendByte(AddrW, 1, "R1");
    sendByte(8'h03, 1, "R1");
    sendByte(8'hF4, 1, "R1");
    busStop();
    check("R1 bass", bassCode, 9);
    check("R1 partial byte dropped", volLeft, 6'h3F);
    check("R1 treble", trebleCode, 4);

    // R11: clocking after a stop without a start
    sendByte(8'h82, 0, "R11");
    sendByte(8'h00, 0, "R11");
    sendByte(8'hC0, 0, "R11");
    check("R11 volLeft kept", volLeft, 6'h3F);
    waitClk(10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule